// File: doc/BRIEF.md
# Nine-Valued Logic Register with Classified Reset

This block is an n-bit storage register in which every signal (the sampling clock, the reset, each data bit and each output bit) carries one of nine logic levels instead of a plain 0/1. Each level is a 4-bit code. A free-running system clock `clk` drives the block. On every `clk` edge the block looks at the previous and present value of the logic clock `lclk` and sorts the transition into one of three kinds: a capturing rise, an unknown transition, or a transition that captures nothing.

The logic reset `lrst` is looked up in a nine-entry class table, which is a parameter. Class 1 forces the stored bits to U. Class 2 forces them to 0. Class 3 leaves normal clocking in control. Class 4 means the reset itself is unknown. Any stored value leaves the block through a selectable strength map, which turns the internal U/X/0/1 state into the level that is driven.

The block suits gate-level style models on a synchronous fabric: a testbench or an emulation core can keep multi-valued state without event-driven simulation. The power-up reset `rst_n` sets every stored bit to U.

Top module: `nvl_register`

## Requirements
- R1: While `rst_n` is low, and after it is released, every stored bit is U and every output nibble reads U (code 0), whatever the strength selection.
- R2: Level codes are U=0, X=1, 0=2, 1=3, Z=4, W=5, L=6, H=7, don't-care=8. Codes 9 to 15 on `lclk`, `lrst` or `din` are handled exactly as X.
- R3: With reset in class 3, a rise of `lclk` (previous level 0, present level 1, with L counted as 0 and H as 1) stores each data nibble as follows. 0/L is stored as 0, 1/H as 1, U as U, and anything else as X.
- R4: With reset in class 3, an unknown transition leaves a bit unchanged when its normalised data equals the stored value, and otherwise sets it to X. An unknown transition is one from 0 to X or U, or from X or U to 1.
- R5: With reset in class 3, every other clock transition leaves the stored bits unchanged. This covers any move to 0, any move away from 1, any move among X and U, and an unchanged level.
- R6: Reset class 1 forces every stored bit to U, whatever the clock does.
- R7: Reset class 2 forces every stored bit to 0, and this overrides a clock rise in the same cycle.
- R8: Reset class 4 keeps a stored 0 as 0 and a stored U as U, and turns any other stored value into X.
- R9: `RESET_MAP` is indexed by the reset code (index 0 = U … index 8 = don't-care) and gives classes 1 to 4. The default is U→1, X→4, 0→3, 1→2, Z→4, W→4, L→3, H→2, don't-care→4.
- R10: The `STRENGTH` index selects an output triple {first, second, third}. The order is 0:X01, 1:X0H, 2:XL1, 3:X0Z, 4:XZ1, 5:WLH, 6:WLZ, 7:WZH, 8:W0H, 9:WL1. A stored U is driven as U, a stored X as the first letter, a stored 0 as the second letter and a stored 1 as the third letter.
- R11: The stored state updates on the `clk` edge that samples the stimulus. The mapped output of that state appears on `dout` after the following `clk` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-up reset; stored bits become U |
| lclk | input | 4 | Nine-valued logic clock level |
| lrst | input | 4 | Nine-valued logic reset level, classified through `RESET_MAP` |
| din | input | 4*WIDTH | Data levels, bit i in nibble [4i+3:4i] |
| dout | output | 4*WIDTH | Strength-mapped stored levels, bit i in nibble [4i+3:4i] |

## Verification
Each stimulus is presented on a falling `clk` edge. The stored state it produces is fixed at the next rising edge. Its mapped value reaches `dout` one rising edge later, so a result is due two edges after the stimulus. The bench model keeps its own state per bit and updates it once per step. For each step it predicts `dout` as the strength map of the state held just before that step's edge, then samples `dout` shortly after the edge. This keeps the one-cycle output lag explicit in every comparison. Two instances with different strength selections are checked in every cycle.

// File: rtl/nvl_pkg.sv
package nvl_pkg;

  typedef logic [3:0] nvl_t;

  localparam nvl_t NV_U  = 4'd0;
  localparam nvl_t NV_X  = 4'd1;
  localparam nvl_t NV_0  = 4'd2;
  localparam nvl_t NV_1  = 4'd3;
  localparam nvl_t NV_Z  = 4'd4;
  localparam nvl_t NV_W  = 4'd5;
  localparam nvl_t NV_L  = 4'd6;
  localparam nvl_t NV_H  = 4'd7;

  localparam int unsigned NUM_CODES     = 9;
  localparam int unsigned NUM_STRENGTHS = 10;

  typedef enum logic [1:0] {
    RC_UNDEF = 2'd0,
    RC_ZERO  = 2'd1,
    RC_IDLE  = 2'd2,
    RC_UNK   = 2'd3
  } rc_e;

  // Collapse a level onto the four-value set U/X/0/1.
  function automatic nvl_t nv_norm(nvl_t v);
    case (v)
      NV_U:       return NV_U;
      NV_0, NV_L: return NV_0;
      NV_1, NV_H: return NV_1;
      default:    return NV_X;
    endcase
  endfunction

  // Out-of-range codes read as X.
  function automatic nvl_t nv_legal(nvl_t v);
    return (v < NUM_CODES) ? v : NV_X;
  endfunction

  // {first, second, third} drive levels of a strength selection.
  function automatic logic [11:0] nv_triple(int unsigned sel);
    case (sel)
      1:       return {NV_X, NV_0, NV_H};
      2:       return {NV_X, NV_L, NV_1};
      3:       return {NV_X, NV_0, NV_Z};
      4:       return {NV_X, NV_Z, NV_1};
      5:       return {NV_W, NV_L, NV_H};
      6:       return {NV_W, NV_L, NV_Z};
      7:       return {NV_W, NV_Z, NV_H};
      8:       return {NV_W, NV_0, NV_H};
      9:       return {NV_W, NV_L, NV_1};
      default: return {NV_X, NV_0, NV_1};
    endcase
  endfunction

  function automatic nvl_t nv_drive(int unsigned sel, nvl_t v);
    logic [11:0] t;
    t = nv_triple(sel);
    case (v)
      NV_U:       return NV_U;
      NV_0, NV_L: return t[7:4];
      NV_1, NV_H: return t[3:0];
      default:    return t[11:8];
    endcase
  endfunction

  // Next stored level of one bit.
  function automatic nvl_t nv_next(nvl_t st, nvl_t d, logic rise, logic unk, rc_e rc);
    nvl_t dn;
    dn = nv_norm(d);
    case (rc)
      RC_UNDEF: return NV_U;
      RC_ZERO:  return NV_0;
      RC_UNK:   return (st == NV_0 || st == NV_U) ? st : NV_X;
      default: begin
        if (rise)     return dn;
        else if (unk) return (dn == st) ? st : NV_X;
        else          return st;
      end
    endcase
  endfunction

endpackage

// File: rtl/nvl_clk_classify.sv
module nvl_clk_classify
  import nvl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  nvl_t lclk,
  output logic is_rise,
  output logic is_unk
);

  nvl_t prev_q;
  nvl_t cur;

  assign cur = nv_norm(lclk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= NV_U;
    else        prev_q <= cur;
  end

  always_comb begin
    is_rise = (prev_q == NV_0) && (cur == NV_1);
    is_unk  = ((prev_q == NV_0) && (cur == NV_X || cur == NV_U)) ||
              ((prev_q == NV_X || prev_q == NV_U) && (cur == NV_1));
  end

  assert_edge_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_rise && is_unk));

  assert_no_rise_from_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == NV_1) |=> !is_rise && !is_unk);

endmodule

// File: rtl/nvl_rst_classify.sv
module nvl_rst_classify
  import nvl_pkg::*;
#(
  parameter logic [8:0][2:0] RESET_MAP = {3'd4, 3'd2, 3'd3, 3'd4, 3'd4, 3'd2, 3'd3, 3'd4, 3'd1}
)(
  input  nvl_t lrst,
  output rc_e  rc
);

  nvl_t       idx;
  logic [2:0] cls;

  assign idx = nv_legal(lrst);
  assign cls = RESET_MAP[idx];

  always_comb begin
    case (cls)
      3'd1:    rc = RC_UNDEF;
      3'd2:    rc = RC_ZERO;
      3'd4:    rc = RC_UNK;
      default: rc = RC_IDLE;
    endcase
  end

endmodule

// File: rtl/nvl_bit_cell.sv
module nvl_bit_cell
  import nvl_pkg::*;
#(
  parameter int unsigned STRENGTH = 0
)(
  input  logic clk,
  input  logic rst_n,
  input  rc_e  rc,
  input  logic is_rise,
  input  logic is_unk,
  input  nvl_t din,
  output nvl_t dout
);

  nvl_t st_q;
  nvl_t st_d;
  nvl_t dout_q;

  assign st_d = nv_next(st_q, din, is_rise, is_unk, rc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= NV_U;
      dout_q <= NV_U;
    end else begin
      st_q   <= st_d;
      dout_q <= nv_drive(STRENGTH, st_q);
    end
  end

  assign dout = dout_q;

  assert_undef_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rc == RC_UNDEF) |=> st_q == NV_U);

  assert_zero_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rc == RC_ZERO) |=> st_q == NV_0);

  assert_unk_reset_keeps_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rc == RC_UNK && st_q == NV_0) |=> st_q == NV_0);

  assert_unk_reset_no_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rc == RC_UNK) |=> st_q != NV_1);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rc == RC_IDLE && !is_rise && !is_unk) |=> $stable(st_q));

  assert_capture_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rc == RC_IDLE && is_rise && (din == NV_1 || din == NV_H)) |=> st_q == NV_1);

  assert_unknown_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rc == RC_IDLE && is_unk) |=> (st_q == $past(st_q) || st_q == NV_X));

  assert_out_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dout_q == nv_drive(STRENGTH, $past(st_q)));

  assert_undef_passes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == NV_U) |=> dout_q == NV_U);

endmodule

// File: rtl/nvl_register.sv
module nvl_register
  import nvl_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned STRENGTH = 0,
  parameter logic [8:0][2:0] RESET_MAP = {3'd4, 3'd2, 3'd3, 3'd4, 3'd4, 3'd2, 3'd3, 3'd4, 3'd1}
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           lclk,
  input  logic [3:0]           lrst,
  input  logic [4*WIDTH-1:0]   din,
  output logic [4*WIDTH-1:0]   dout
);

  localparam int unsigned CW = $bits(nvl_t);

  logic is_rise;
  logic is_unk;
  rc_e  rc;

  nvl_clk_classify u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lclk    (lclk),
    .is_rise (is_rise),
    .is_unk  (is_unk)
  );

  nvl_rst_classify #(.RESET_MAP(RESET_MAP)) u_rst (
    .lrst (lrst),
    .rc   (rc)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    nvl_bit_cell #(.STRENGTH(STRENGTH)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .rc      (rc),
      .is_rise (is_rise),
      .is_unk  (is_unk),
      .din     (din[b*CW +: CW]),
      .dout    (dout[b*CW +: CW])
    );
  end

  initial begin
    assert_strength_range_R10: assert (STRENGTH < NUM_STRENGTHS);
  end

endmodule

// File: tb/tb_nvl_register.sv
`timescale 1ns/1ps
module tb_nvl_register;

  localparam int W = 8;
  localparam int SB = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic [3:0]     lclk, lrst;
  logic [4*W-1:0] din, dout_a, dout_b;

  nvl_register #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .lclk(lclk), .lrst(lrst), .din(din), .dout(dout_a));

  nvl_register #(.WIDTH(W), .STRENGTH(SB)) dut_b (
    .clk(clk), .rst_n(rst_n), .lclk(lclk), .lrst(lrst), .din(din), .dout(dout_b));

  int compared = 0;
  int mismatched = 0;
  int model_st[W];
  int prev_clk;
  string smap[10] = '{"X01","X0H","XL1","X0Z","XZ1","WLH","WLZ","WZH","W0H","WL1"};
  int rmap[9] = '{1, 4, 3, 2, 4, 4, 3, 2, 4};

  function automatic int letter(byte ch);
    if (ch == "X") return 1;
    if (ch == "0") return 2;
    if (ch == "1") return 3;
    if (ch == "Z") return 4;
    if (ch == "W") return 5;
    if (ch == "L") return 6;
    return 7;
  endfunction

  function automatic int drive(int sel, int v);
    string s;
    s = smap[sel];
    if (v == 0) return 0;
    if (v == 2) return letter(s[1]);
    if (v == 3) return letter(s[2]);
    return letter(s[0]);
  endfunction

  function automatic int norm(int v);
    if (v == 0) return 0;
    if (v == 2 || v == 6) return 2;
    if (v == 3 || v == 7) return 3;
    return 1;
  endfunction

  function automatic logic [4*W-1:0] pk(int a, int b, int c, int d, int e, int f, int g, int h);
    logic [4*W-1:0] r;
    r = {h[3:0], g[3:0], f[3:0], e[3:0], d[3:0], c[3:0], b[3:0], a[3:0]};
    return r;
  endfunction

  task automatic check(string tag, logic [4*W-1:0] got, logic [4*W-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: dout=%h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(string tag, int c, int r, logic [4*W-1:0] d);
    logic [4*W-1:0] ea, eb;
    int cls, cu, p;
    bit rise, unk;
    @(negedge clk);
    lclk = c[3:0];
    lrst = r[3:0];
    din  = d;
    for (int b = 0; b < W; b++) begin
      ea[4*b +: 4] = drive(0, model_st[b]);
      eb[4*b +: 4] = drive(SB, model_st[b]);
    end
    cls  = rmap[(r > 8) ? 1 : r];
    p    = prev_clk;
    cu   = norm(c);
    rise = (p == 2 && cu == 3);
    unk  = (p == 2 && (cu == 1 || cu == 0)) || ((p == 1 || p == 0) && cu == 3);
    for (int b = 0; b < W; b++) begin
      int dv;
      dv = norm(int'(d[4*b +: 4]));
      if (cls == 1)      model_st[b] = 0;
      else if (cls == 2) model_st[b] = 2;
      else if (cls == 4) model_st[b] = (model_st[b] == 2 || model_st[b] == 0) ? model_st[b] : 1;
      else if (rise)     model_st[b] = dv;
      else if (unk)      model_st[b] = (dv == model_st[b]) ? model_st[b] : 1;
    end
    prev_clk = cu;
    @(posedge clk);
    #1;
    check(tag, dout_a, ea);
    check(tag, dout_b, eb);
  endtask

  initial begin
    #400000;
    compared++;
    mismatched++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lclk = 4'd0; lrst = 4'd2; din = '0;
    for (int b = 0; b < W; b++) model_st[b] = 0;
    prev_clk = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset", dout_a, '0);
    check("R1 during reset", dout_b, '0);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1 after release", 0, 2, '0);
    step("R5 U to 0 no capture", 2, 2, pk(3,3,3,3,3,3,3,3));
    step("R3 rise captures", 3, 2, pk(2,3,6,7,4,5,0,8));
    step("R11 R10 hold at 1", 3, 2, pk(2,2,2,2,2,2,2,2));
    step("R11 R10 captured out", 2, 2, pk(3,3,3,3,3,3,3,3));
    step("R4 0 to X", 1, 2, pk(2,2,3,3,1,0,0,6));
    step("R4 X to 1", 3, 2, pk(3,3,3,3,3,3,3,3));
    step("R5 1 to X", 1, 2, pk(2,2,2,2,2,2,2,2));
    step("R5 X to 0", 2, 2, pk(3,3,3,3,3,3,3,3));
    step("R3 rise to L", 6, 2, pk(3,2,3,2,3,2,3,2));
    step("R3 L to H", 7, 2, pk(3,2,7,6,3,2,7,6));
    step("R7 drop clock", 2, 2, pk(3,3,3,3,3,3,3,3));
    step("R7 reset over rise", 3, 3, pk(3,3,3,3,3,3,3,3));
    step("R8 X reset keeps 0", 2, 1, pk(3,3,3,3,3,3,3,3));
    step("R9 L is idle", 3, 6, pk(3,2,3,2,3,2,3,2));
    step("R8 W reset", 2, 5, pk(3,3,3,3,3,3,3,3));
    step("R9 H reset is zero", 2, 7, '0);
    step("R6 U reset", 3, 0, pk(3,3,3,3,3,3,3,3));
    step("R8 dc reset keeps U", 2, 8, '0);
    step("R2 idle prep", 2, 2, pk(3,2,3,2,3,2,3,2));
    step("R2 capture", 3, 2, pk(3,2,3,2,3,2,3,2));
    step("R2 illegal reset code", 3, 12, '0);
    step("R2 idle low", 2, 2, '0);
    step("R2 illegal clock code", 15, 2, pk(2,3,2,3,11,2,3,2));
    step("R2 illegal data code", 3, 2, pk(9,10,11,12,13,14,15,2));
    for (int i = 0; i < 400; i++) begin
      int c, r;
      logic [4*W-1:0] d;
      c = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : ((i % 2 == 0) ? 2 : 3);
      r = ($urandom_range(0, 4) == 0) ? $urandom_range(0, 15) : 2;
      for (int b = 0; b < W; b++) d[4*b +: 4] = 4'($urandom_range(0, 15));
      step("R9 R3 R4 random mix", c, r, d);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule